// File: doc/BRIEF.md
# Dual-Channel DAC Serial Register Interface

This block is the digital front end of a two-channel 12-bit converter. A host writes 16-bit words over three wires: an active-low frame select, a serial clock and a data line. Bits are taken most significant first on each falling serial-clock edge. When a word is complete, or when the frame select is released early, the captured word is committed to one of four latches. The four latches are channel A code, channel B code, a holding buffer and a control register. Two control bits inside the word choose the latch.

The three serial lines are oversampled by the block's own clock. Each line passes through a synchronizer of `SYNC_STAGES` flops, and its edges are found in the clock domain. Every level on the serial lines must therefore persist for more than `SYNC_STAGES + 1` clock cycles. The holding buffer allows both outputs to change in the same cycle. The host loads the buffer with the channel B value, then writes channel A; at that moment the buffer value is copied into channel B as well. A host that moves 8 bits per transfer keeps the frame select low and sends two bytes. The 16th bit commits the word.

Top module: `dual_dac_serial_front`

## Requirements
- R1: After reset, both channel codes, the reference select, the power-down flag, the speed flag and the commit strobe are all zero.
- R2: A falling edge of `cs_n` opens a frame and clears the bit count. Each falling edge of `sclk` while the frame is open shifts in `sdin`, most significant bit first. In the word, bits 11:0 are data and the pair {bit 15, bit 12} picks the target: 00 channel A, 01 buffer, 10 control, 11 channel B.
- R3: The 16th bit of a frame commits the word at once, without waiting for `cs_n` to rise; target 00 loads bits 11:0 into `chan_a_code`.
- R4: Target 11 loads bits 11:0 into `chan_b_code` and leaves `chan_a_code` unchanged.
- R5: Target 01 stores bits 11:0 in the buffer and changes no output. A later channel A commit copies the buffer into `chan_b_code` in the same cycle that it loads `chan_a_code`.
- R6: Target 10 loads the control fields from the word: bits 1:0 become `ref_sel`, bit 2 becomes `power_down` and bit 3 becomes `speed_fast`.
- R7: If `cs_n` rises after n bits, with 1 ≤ n ≤ 15, the word committed holds those n bits right-aligned, with zeros above.
- R8: If `cs_n` rises before any bit of the frame, nothing is committed.
- R9: A frame commits at most once. Serial-clock edges after the 16th bit are ignored, and the rise of `cs_n` after a full frame commits nothing more.
- R10: Serial-clock falling edges while `cs_n` is high add no bits and do not disturb the next frame.
- R11: Two 8-bit transfers sent with `cs_n` held low, with an idle gap between them, form one 16-bit frame.
- R12: `commit_valid` is high for exactly one cycle per commit. That cycle is the one in which the latch outputs show the new value.
- R13: The outputs `chan_a_code`, `chan_b_code`, `ref_sel`, `power_down` and `speed_fast` change only in a cycle where `commit_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idles high, data taken on falling edges |
| sdin | input | 1 | Serial data, most significant bit first |
| chan_a_code | output | 12 | Channel A converter code |
| chan_b_code | output | 12 | Channel B converter code |
| ref_sel | output | 2 | Reference select field |
| power_down | output | 1 | Power-down flag |
| speed_fast | output | 1 | Fast settling mode flag |
| commit_valid | output | 1 | One-cycle strobe marking a latch update |

## Verification
A bit counter or frame flag in the wrong state shows at the ports as a wrong word in a latch: the data is shifted sideways, a target is misrouted, or a commit is missing or doubled. These faults appear one clock after the frame's 16th edge or after the `cs_n` rise. A stale buffer cannot be seen until the next channel A commit, so each buffer write is followed at once by a channel A write. The strobe count is compared with the number of commits the bench expects after every scenario, so a lost or extra commit is reported at the end of the scenario in which it happens.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

  localparam int WORD_W = 16;
  localparam int DATA_W = 12;
  localparam int CTRL_W = 4;

  typedef enum logic [1:0] {
    TGT_CHAN_A  = 2'b00,
    TGT_BUFFER  = 2'b01,
    TGT_CONTROL = 2'b10,
    TGT_CHAN_B  = 2'b11
  } target_e;

  typedef struct packed {
    logic       speed_fast;
    logic       power_down;
    logic [1:0] ref_sel;
  } ctrl_t;

  // Target latch chosen by the two steering bits of a word.
  function automatic target_e word_target(input logic [WORD_W-1:0] w);
    return target_e'({w[WORD_W-1], w[DATA_W]});
  endfunction

  // Converter code carried in the low part of a word.
  function automatic logic [DATA_W-1:0] word_data(input logic [WORD_W-1:0] w);
    return w[DATA_W-1:0];
  endfunction

  // Control fields carried in the lowest bits of a control word.
  function automatic ctrl_t word_ctrl(input logic [WORD_W-1:0] w);
    return ctrl_t'(w[CTRL_W-1:0]);
  endfunction

endpackage

// File: rtl/dsf_sync_line.sv
module dsf_sync_line #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= IDLE;
        else        pipe <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= {STAGES{IDLE}};
        else        pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/dsf_frame_shifter.sv
module dsf_frame_shifter #(
  parameter int WORD_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_lvl,
  input  logic                 sclk_lvl,
  input  logic                 sd_lvl,
  output logic                 frame_start,
  output logic                 sclk_fall,
  output logic                 in_frame,
  output logic                 commit_pulse,
  output logic [WORD_BITS-1:0] commit_word,
  output logic [$clog2(WORD_BITS+1)-1:0] bit_count
);

  localparam int CW = $clog2(WORD_BITS + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(WORD_BITS - 1);

  logic                 cs_prev;
  logic                 sclk_prev;
  logic                 frame_done;
  logic [WORD_BITS-1:0] shreg;
  logic                 cs_rise;
  logic                 shift_evt;
  logic                 full_evt;
  logic                 early_evt;

  assign frame_start = cs_prev & ~cs_lvl;
  assign cs_rise     = ~cs_prev & cs_lvl;
  assign sclk_fall   = sclk_prev & ~sclk_lvl;
  assign shift_evt   = sclk_fall & in_frame & ~cs_lvl & ~frame_done;
  assign full_evt    = shift_evt & (bit_count == LAST_BIT);
  assign early_evt   = cs_rise & in_frame & ~frame_done & (bit_count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev   <= 1'b1;
      sclk_prev <= 1'b1;
    end else begin
      cs_prev   <= cs_lvl;
      sclk_prev <= sclk_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame   <= 1'b0;
      frame_done <= 1'b0;
      shreg      <= '0;
      bit_count  <= '0;
    end else if (frame_start) begin
      in_frame   <= 1'b1;
      frame_done <= 1'b0;
      shreg      <= '0;
      bit_count  <= '0;
    end else if (cs_rise) begin
      in_frame   <= 1'b0;
    end else if (shift_evt) begin
      shreg      <= {shreg[WORD_BITS-2:0], sd_lvl};
      bit_count  <= bit_count + 1'b1;
      frame_done <= full_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_pulse <= 1'b0;
      commit_word  <= '0;
    end else begin
      commit_pulse <= full_evt | early_evt;
      if (full_evt)       commit_word <= {shreg[WORD_BITS-2:0], sd_lvl};
      else if (early_evt) commit_word <= shreg;
    end
  end

endmodule

// File: rtl/dsf_latch_bank.sv
module dsf_latch_bank
  import dsf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_pulse,
  input  logic [WORD_W-1:0] commit_word,
  output logic [DATA_W-1:0] chan_a_q,
  output logic [DATA_W-1:0] chan_b_q,
  output logic [DATA_W-1:0] buf_q,
  output ctrl_t             ctrl_q,
  output logic              commit_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_a_q     <= '0;
      chan_b_q     <= '0;
      buf_q        <= '0;
      ctrl_q       <= '0;
      commit_valid <= 1'b0;
    end else begin
      commit_valid <= commit_pulse;
      if (commit_pulse) begin
        unique case (word_target(commit_word))
          TGT_CHAN_A: begin
            chan_a_q <= word_data(commit_word);
            chan_b_q <= buf_q;
          end
          TGT_CHAN_B:  chan_b_q <= word_data(commit_word);
          TGT_BUFFER:  buf_q    <= word_data(commit_word);
          TGT_CONTROL: ctrl_q   <= word_ctrl(commit_word);
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dual_dac_serial_front.sv
module dual_dac_serial_front
  import dsf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdin,
  output logic [DATA_W-1:0] chan_a_code,
  output logic [DATA_W-1:0] chan_b_code,
  output logic [1:0]        ref_sel,
  output logic              power_down,
  output logic              speed_fast,
  output logic              commit_valid
);

  localparam int N_LINES = 3;
  localparam int CW      = $clog2(WORD_W + 1);
  // Idle level of each line: index 0 data, 1 serial clock, 2 frame select.
  localparam logic [N_LINES-1:0] IDLE_LVL = 3'b110;

  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] sync_lines;

  logic              frame_start;
  logic              sclk_fall;
  logic              in_frame;
  logic              commit_pulse;
  logic [WORD_W-1:0] commit_word;
  logic [CW-1:0]     bit_count;
  target_e           commit_tgt;
  logic [DATA_W-1:0] buf_code;
  ctrl_t             ctrl_q;

  assign raw_lines = {cs_n, sclk, sdin};

  generate
    for (genvar i = 0; i < N_LINES; i++) begin : g_sync
      dsf_sync_line #(
        .STAGES (SYNC_STAGES),
        .IDLE   (IDLE_LVL[i])
      ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_lines[i]),
        .dout  (sync_lines[i])
      );
    end
  endgenerate

  dsf_frame_shifter #(
    .WORD_BITS (WORD_W)
  ) u_shifter (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_lvl       (sync_lines[2]),
    .sclk_lvl     (sync_lines[1]),
    .sd_lvl       (sync_lines[0]),
    .frame_start  (frame_start),
    .sclk_fall    (sclk_fall),
    .in_frame     (in_frame),
    .commit_pulse (commit_pulse),
    .commit_word  (commit_word),
    .bit_count    (bit_count)
  );

  dsf_latch_bank u_latches (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit_pulse (commit_pulse),
    .commit_word  (commit_word),
    .chan_a_q     (chan_a_code),
    .chan_b_q     (chan_b_code),
    .buf_q        (buf_code),
    .ctrl_q       (ctrl_q),
    .commit_valid (commit_valid)
  );

  assign commit_tgt = word_target(commit_word);
  assign ref_sel    = ctrl_q.ref_sel;
  assign power_down = ctrl_q.power_down;
  assign speed_fast = ctrl_q.speed_fast;

endmodule

// File: rtl/dsf_checker.sv
module dsf_checker
  import dsf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              sclk_fall,
  input logic              in_frame,
  input logic              commit_pulse,
  input logic [WORD_W-1:0] commit_word,
  input target_e           commit_tgt,
  input logic [$clog2(WORD_W+1)-1:0] bit_count,
  input logic [DATA_W-1:0] buf_code,
  input logic [DATA_W-1:0] chan_a_code,
  input logic [DATA_W-1:0] chan_b_code,
  input logic [1:0]        ref_sel,
  input logic              power_down,
  input logic              speed_fast,
  input logic              commit_valid
);

  logic commits_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            commits_seen <= 1'b0;
    else if (frame_start)  commits_seen <= 1'b0;
    else if (commit_pulse) commits_seen <= 1'b1;
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> !commit_valid); // R12

  AST_OUTPUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_valid |-> ($stable(chan_a_code) && $stable(chan_b_code) && $stable(ref_sel)
                       && $stable(power_down) && $stable(speed_fast))); // R13

  AST_A_COPIES_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pulse && commit_tgt == TGT_CHAN_A) |=> chan_b_code == $past(buf_code)); // R5

  AST_B_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pulse && commit_tgt == TGT_CHAN_B) |=>
      ($stable(chan_a_code) && chan_b_code == $past(commit_word[DATA_W-1:0]))); // R4

  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> !commits_seen); // R9

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_count <= ($clog2(WORD_W+1))'(WORD_W)); // R2

  AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall && !in_frame && !frame_start) |=> $stable(bit_count)); // R10

endmodule

bind dual_dac_serial_front dsf_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_start  (frame_start),
  .sclk_fall    (sclk_fall),
  .in_frame     (in_frame),
  .commit_pulse (commit_pulse),
  .commit_word  (commit_word),
  .commit_tgt   (commit_tgt),
  .bit_count    (bit_count),
  .buf_code     (buf_code),
  .chan_a_code  (chan_a_code),
  .chan_b_code  (chan_b_code),
  .ref_sel      (ref_sel),
  .power_down   (power_down),
  .speed_fast   (speed_fast),
  .commit_valid (commit_valid)
);

// File: tb/dual_dac_serial_front_test.sv
module dual_dac_serial_front_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int SETTLE     = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b1;
  logic        sdin = 1'b0;
  logic [11:0] chan_a_code;
  logic [11:0] chan_b_code;
  logic [1:0]  ref_sel;
  logic        power_down;
  logic        speed_fast;
  logic        commit_valid;

  int checks = 0;
  int fails = 0;
  int strobes = 0;

  int exp_a = 0, exp_b = 0, exp_buf = 0, exp_ref = 0, exp_pd = 0, exp_fast = 0;
  int exp_commits = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dac_serial_front uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdin(sdin),
    .chan_a_code(chan_a_code), .chan_b_code(chan_b_code), .ref_sel(ref_sel),
    .power_down(power_down), .speed_fast(speed_fast), .commit_valid(commit_valid)
  );

  always @(negedge clk) if (rst_n && commit_valid) strobes++;

  task automatic check(input string req, input string what, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Reference model of one commit, written from the requirements.
  task automatic model_commit(input int word);
    int sel;
    sel = ((word >> 14) & 2) | ((word >> 12) & 1);
    exp_commits++;
    if (sel == 0) begin exp_b = exp_buf; exp_a = word % 4096; end
    else if (sel == 1) exp_buf = word % 4096;
    else if (sel == 3) exp_b = word % 4096;
    else begin
      exp_ref  = word % 4;
      exp_pd   = (word / 4) % 2;
      exp_fast = (word / 8) % 2;
    end
  endtask

  task automatic send_bits(input logic [15:0] word, input int n);
    for (int i = 15; i > 15 - n; i--) begin
      sdin = word[i];
      idle(HALF);
      sclk = 1'b0;
      idle(HALF);
      sclk = 1'b1;
    end
  endtask

  task automatic frame(input logic [15:0] word, input int n);
    cs_n = 1'b0;
    idle(HALF);
    send_bits(word, n);
    idle(HALF);
    cs_n = 1'b1;
    idle(SETTLE);
  endtask

  task automatic check_state(input string req);
    check(req, "chan_a_code", chan_a_code, exp_a);
    check(req, "chan_b_code", chan_b_code, exp_b);
    check(req, "ref_sel", ref_sel, exp_ref);
    check(req, "power_down", power_down, exp_pd);
    check(req, "speed_fast", speed_fast, exp_fast);
    check(req, "commit count", strobes, exp_commits);
  endtask

  task automatic t_reset;
    check_state("R1");
  endtask

  task automatic t_chan_a;
    frame(16'h0ABC, 16); model_commit('h0ABC);
    check_state("R2 R3 chan A write");
  endtask

  task automatic t_chan_b;
    frame(16'h9123, 16); model_commit('h9123);
    check_state("R4 chan B write");
  endtask

  task automatic t_buffer_pair;
    frame(16'h1456, 16); model_commit('h1456);
    check_state("R5 buffer write changes no output");
    frame(16'h0789, 16); model_commit('h0789);
    check_state("R5 chan A pulls buffer into B");
    check("R5", "chan_b from buffer", chan_b_code, 'h456);
  endtask

  task automatic t_control;
    frame(16'h800D, 16); model_commit('h800D);
    check_state("R6 control fields 1101");
    frame(16'hA002, 16); model_commit('hA002);
    check_state("R6 control fields 0010");
  endtask

  task automatic t_truncated;
    frame(16'h5A00, 8); model_commit('h005A);
    check_state("R7 eight bits");
    frame(16'hABCD, 13); model_commit('h1579);
    check_state("R7 thirteen bits to buffer");
    frame(16'h0111, 16); model_commit('h0111);
    check_state("R7 buffer from truncated frame");
  endtask

  task automatic t_empty;
    frame(16'h0000, 0);
    check_state("R8 R13 empty frame");
  endtask

  task automatic t_overrun;
    cs_n = 1'b0;
    idle(HALF);
    send_bits(16'h9CAB, 16);
    idle(SETTLE);
    model_commit('h9CAB);
    check_state("R3 commit before cs_n rises");
    send_bits(16'hFFFF, 4);
    idle(HALF);
    cs_n = 1'b1;
    idle(SETTLE);
    check_state("R9 extra edges and cs_n rise ignored");
  endtask

  task automatic t_idle_sclk;
    send_bits(16'hFFFF, 5);
    idle(SETTLE);
    check_state("R10 clock edges with cs_n high");
    frame(16'h0321, 16); model_commit('h0321);
    check_state("R10 next frame unaffected");
  endtask

  task automatic t_bytes;
    cs_n = 1'b0;
    idle(HALF);
    send_bits(16'h9A00, 8);
    idle(20);
    check("R11", "no commit after first byte", strobes, exp_commits);
    send_bits(16'hCE00, 8);
    idle(SETTLE);
    model_commit('h9ACE);
    check_state("R11 two bytes form one frame");
    cs_n = 1'b1;
    idle(SETTLE);
    check_state("R9 R12 no second commit on cs_n rise");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(5);
    t_reset;
    rst_n = 1'b1;
    idle(5);
    t_reset;
    t_chan_a;
    t_chan_b;
    t_buffer_pair;
    t_control;
    t_truncated;
    t_empty;
    t_overrun;
    t_idle_sclk;
    t_bytes;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule